// File: doc/BRIEF.md
# Partitioned Preselect and Select

This block picks which instructions leave a segmented issue window each cycle. The window is split into equal segments. The first segment feeds the final selector directly, one line per entry. Each later segment has its own preselector. A preselector scans only its own segment and keeps, in a register, the few oldest entries that are still eligible. The final selector then fills the issue slots from the first segment's eligible entries and those forwarded candidates, oldest first.

Each entry has a ready line and an age value. A lower age means an older instruction. Equal ages go to the lower entry index. Each cycle the block reports the chosen entries in two forms: one index per issue slot, with a valid bit, and one grant vector with a bit per entry. An entry that has been granted is blocked until its ready line falls. The block that owns the window is expected to drop ready once the instruction has left.

Top module: `psel_issue`

## Requirements
- R1: During reset and in the first cycle after it, no slot is valid and the grant vector is zero, even if entries outside the first segment are ready.
- R2: An eligible first-segment entry that is among the oldest eligible candidates is granted in the same cycle its ready line is high, with no register in its path.
- R3: An entry outside the first segment is granted no earlier than the cycle after the cycle in which it was ready, because its preselector output is registered.
- R4: In any cycle, at most CANDS (default 1) entries of each segment other than the first are granted.
- R5: Slots are filled oldest-first. Slot 0 holds the entry with the lowest age among the candidates, and equal ages go to the lower entry index. The same order decides which entries a preselector forwards.
- R6: Valid slots are contiguous from slot 0. When fewer candidates exist than ISSUE_W (default 4), the remaining slots have their valid bit low and their index field at zero.
- R7: A granted entry whose ready line stays high is not granted again. After ready falls and rises again, the entry can be granted again.
- R8: Bit i of the grant vector is set exactly when some valid slot carries index i. The number of set grant bits equals the number of valid slots.
- R9: Only entries whose ready line is high in the current cycle are granted. A forwarded candidate whose ready line has fallen since it was registered is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| entry_rdy | input | SEGS*SEG_N | Ready line per window entry; entry i is in segment i/SEG_N |
| entry_age | input | SEGS*SEG_N*AGE_W | Age per entry, entry i in bits [i*AGE_W +: AGE_W]; lower is older |
| slot_vld | output | ISSUE_W | Valid bit per issue slot |
| slot_idx | output | ISSUE_W*IDX_W | Entry index per slot, slot k in bits [k*IDX_W +: IDX_W] |
| grant | output | SEGS*SEG_N | One bit per entry granted this cycle |

## Verification
The checker tests every cycle that slots fill contiguously, that idle slots carry index zero, that slots appear in age order, that grants agree with the slot list and with the ready lines, that each later segment gets at most its quota, that later-segment grants follow a ready cycle, and that an entry held ready is not granted twice in a row. Other behaviour depends on history across several cycles and is left to the bench scenarios, which run a reference model of the same preselection restriction. These scenarios cover which entry a preselector forwards, whether a candidate is lost when its ready line drops, re-granting after ready falls and rises again, and the quiet cycle right after reset.

// File: rtl/psel_pkg.sv
package psel_pkg;

  localparam int KEY_W = 16;

  // Age comparison shared by every picker: lower age wins, lower index breaks ties.
  function automatic logic is_older(input logic [KEY_W-1:0] age_a,
                                    input logic [KEY_W-1:0] idx_a,
                                    input logic [KEY_W-1:0] age_b,
                                    input logic [KEY_W-1:0] idx_b);
    return (age_a < age_b) || ((age_a == age_b) && (idx_a < idx_b));
  endfunction

endpackage

// File: rtl/psel_oldest_pick.sv
module psel_oldest_pick #(
  parameter int N     = 8,
  parameter int PICKS = 1,
  parameter int AGE_W = 6,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]           cand_vld,
  input  logic [N*AGE_W-1:0]     cand_age,
  input  logic [N*IDX_W-1:0]     cand_idx,
  output logic [PICKS-1:0]       pick_vld,
  output logic [PICKS*IDX_W-1:0] pick_idx
);
  import psel_pkg::*;

  always_comb begin
    logic [N-1:0] left;
    logic         found;
    int           best;
    left     = cand_vld;
    pick_vld = '0;
    pick_idx = '0;
    for (int p = 0; p < PICKS; p++) begin
      found = 1'b0;
      best  = 0;
      for (int i = 0; i < N; i++) begin
        if (left[i] && (!found ||
            is_older(KEY_W'(cand_age[i*AGE_W +: AGE_W]),    KEY_W'(cand_idx[i*IDX_W +: IDX_W]),
                     KEY_W'(cand_age[best*AGE_W +: AGE_W]), KEY_W'(cand_idx[best*IDX_W +: IDX_W])))) begin
          found = 1'b1;
          best  = i;
        end
      end
      if (found) begin
        pick_vld[p]                  = 1'b1;
        pick_idx[p*IDX_W +: IDX_W]   = cand_idx[best*IDX_W +: IDX_W];
        left[best]                   = 1'b0;
      end
    end
  end

endmodule

// File: rtl/psel_presel.sv
module psel_presel #(
  parameter int SEG_N = 8,
  parameter int CANDS = 1,
  parameter int AGE_W = 6,
  parameter int IDX_W = 5,
  parameter int BASE  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEG_N-1:0]       seg_elig,
  input  logic [SEG_N*AGE_W-1:0] seg_age,
  output logic [CANDS-1:0]       cand_vld_q,
  output logic [CANDS*IDX_W-1:0] cand_idx_q
);
  logic [SEG_N*IDX_W-1:0] idx_list;
  logic [CANDS-1:0]       pick_vld;
  logic [CANDS*IDX_W-1:0] pick_idx;

  for (genvar i = 0; i < SEG_N; i++) begin : g_idx
    assign idx_list[i*IDX_W +: IDX_W] = IDX_W'(BASE + i);
  end

  psel_oldest_pick #(.N(SEG_N), .PICKS(CANDS), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
    .cand_vld (seg_elig),
    .cand_age (seg_age),
    .cand_idx (idx_list),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_vld_q <= '0;
      cand_idx_q <= '0;
    end else begin
      cand_vld_q <= pick_vld;
      cand_idx_q <= pick_idx;
    end
  end

endmodule

// File: rtl/psel_issue.sv
module psel_issue #(
  parameter int SEGS    = 4,
  parameter int SEG_N   = 8,
  parameter int CANDS   = 1,
  parameter int ISSUE_W = 4,
  parameter int AGE_W   = 6,
  localparam int ENTRIES = SEGS * SEG_N,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ENTRIES-1:0]       entry_rdy,
  input  logic [ENTRIES*AGE_W-1:0] entry_age,
  output logic [ISSUE_W-1:0]       slot_vld,
  output logic [ISSUE_W*IDX_W-1:0] slot_idx,
  output logic [ENTRIES-1:0]       grant
);
  localparam int FWD  = (SEGS - 1) * CANDS;
  localparam int POOL = SEG_N + FWD;

  logic [ENTRIES-1:0]    issued_q;
  logic [ENTRIES-1:0]    elig;        // ready and not yet issued, this cycle
  logic [ENTRIES-1:0]    presel_elig; // what preselectors may register for next cycle
  logic [FWD-1:0]        fwd_vld;
  logic [FWD*IDX_W-1:0]  fwd_idx;
  logic [FWD-1:0]        fwd_live;    // forwarded candidates still eligible now
  logic [POOL-1:0]       pool_vld;
  logic [POOL*AGE_W-1:0] pool_age;
  logic [POOL*IDX_W-1:0] pool_idx;

  assign elig        = entry_rdy & ~issued_q;
  assign presel_elig = entry_rdy & ~(issued_q | grant);

  // One registered preselector per segment after the first.
  for (genvar s = 1; s < SEGS; s++) begin : g_seg
    psel_presel #(.SEG_N(SEG_N), .CANDS(CANDS), .AGE_W(AGE_W), .IDX_W(IDX_W), .BASE(s*SEG_N)) u_pre (
      .clk        (clk),
      .rst_n      (rst_n),
      .seg_elig   (presel_elig[s*SEG_N +: SEG_N]),
      .seg_age    (entry_age[s*SEG_N*AGE_W +: SEG_N*AGE_W]),
      .cand_vld_q (fwd_vld[(s-1)*CANDS +: CANDS]),
      .cand_idx_q (fwd_idx[(s-1)*CANDS*IDX_W +: CANDS*IDX_W])
    );
  end

  // Final pool: whole first segment, then forwarded candidates.
  for (genvar i = 0; i < SEG_N; i++) begin : g_first
    assign pool_vld[i]                 = elig[i];
    assign pool_age[i*AGE_W +: AGE_W]  = entry_age[i*AGE_W +: AGE_W];
    assign pool_idx[i*IDX_W +: IDX_W]  = IDX_W'(i);
  end

  for (genvar f = 0; f < FWD; f++) begin : g_fwd
    logic [IDX_W-1:0] fi;
    assign fi                                  = fwd_idx[f*IDX_W +: IDX_W];
    assign fwd_live[f]                         = fwd_vld[f] & elig[fi];
    assign pool_vld[SEG_N+f]                   = fwd_live[f];
    assign pool_age[(SEG_N+f)*AGE_W +: AGE_W]  = entry_age[fi*AGE_W +: AGE_W];
    assign pool_idx[(SEG_N+f)*IDX_W +: IDX_W]  = fi;
  end

  psel_oldest_pick #(.N(POOL), .PICKS(ISSUE_W), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_final (
    .cand_vld (pool_vld),
    .cand_age (pool_age),
    .cand_idx (pool_idx),
    .pick_vld (slot_vld),
    .pick_idx (slot_idx)
  );

  always_comb begin
    grant = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      if (slot_vld[k]) grant[slot_idx[k*IDX_W +: IDX_W]] = 1'b1;
    end
  end

  // Issued marks persist while ready stays high; falling ready frees the entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issued_q <= '0;
    else        issued_q <= (issued_q | grant) & entry_rdy;
  end

endmodule

// File: rtl/psel_issue_chk.sv
module psel_issue_chk #(
  parameter int SEGS    = 4,
  parameter int SEG_N   = 8,
  parameter int CANDS   = 1,
  parameter int ISSUE_W = 4,
  parameter int AGE_W   = 6,
  localparam int ENTRIES = SEGS * SEG_N,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ENTRIES-1:0]       entry_rdy,
  input logic [ENTRIES*AGE_W-1:0] entry_age,
  input logic [ISSUE_W-1:0]       slot_vld,
  input logic [ISSUE_W*IDX_W-1:0] slot_idx,
  input logic [ENTRIES-1:0]       grant
);
  import psel_pkg::*;

  // R9
  rdy_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~entry_rdy) == '0);

  // R8
  grant_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == $countones(slot_vld));

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
    logic [IDX_W-1:0] sidx;
    assign sidx = slot_idx[k*IDX_W +: IDX_W];
    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_vld[k] |-> (sidx == '0));
    // R8
    slot_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[k] |-> grant[sidx]);
    if (k + 1 < ISSUE_W) begin : g_pair
      logic [IDX_W-1:0] nidx;
      logic             next_older;
      assign nidx       = slot_idx[(k+1)*IDX_W +: IDX_W];
      assign next_older = is_older(KEY_W'(entry_age[nidx*AGE_W +: AGE_W]), KEY_W'(nidx),
                                   KEY_W'(entry_age[sidx*AGE_W +: AGE_W]), KEY_W'(sidx));
      // R6
      contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[k+1] |-> slot_vld[k]);
      // R5
      age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[k+1] |-> !next_older);
    end
  end

  for (genvar s = 1; s < SEGS; s++) begin : g_seg
    // R4
    seg_quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant[s*SEG_N +: SEG_N]) <= CANDS);
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    if (i >= SEG_N) begin : g_late
      // R3
      late_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant[i] |-> $past(entry_rdy[i]));
    end
    // R7
    no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant[i]) && $past(entry_rdy[i]) && entry_rdy[i]) |-> !grant[i]);
  end

endmodule

bind psel_issue psel_issue_chk #(
  .SEGS(SEGS), .SEG_N(SEG_N), .CANDS(CANDS), .ISSUE_W(ISSUE_W), .AGE_W(AGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .entry_rdy(entry_rdy), .entry_age(entry_age),
  .slot_vld(slot_vld), .slot_idx(slot_idx), .grant(grant)
);

// File: tb/psel_issue_bench.sv
module psel_issue_bench;
  localparam int NE = 32;
  localparam int AW = 6;
  localparam int IW = 5;
  localparam int NS = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NE-1:0]   rdy = '0;
  logic [NE*AW-1:0] age_bus;
  logic [3:0]      slot_vld;
  logic [4*IW-1:0] slot_idx;
  logic [NE-1:0]   grant;
  logic [AW-1:0]   ages [NE];

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  // Reference model state
  logic [NE-1:0] m_iss;
  logic          m_cv [NS-1];
  logic [IW-1:0] m_ci [NS-1];
  logic [3:0]    e_vld;
  logic [IW-1:0] e_idx [4];
  logic [NE-1:0] e_grant;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NE; i++) age_bus[i*AW +: AW] = ages[i];
  end

  psel_issue u_psel_issue (
    .clk(clk), .rst_n(rst_n), .entry_rdy(rdy), .entry_age(age_bus),
    .slot_vld(slot_vld), .slot_idx(slot_idx), .grant(grant)
  );

  function automatic logic [AW+IW-1:0] key(input int i);
    return {ages[i], IW'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_iss = '0;
    for (int s = 0; s < NS-1; s++) begin m_cv[s] = 1'b0; m_ci[s] = '0; end
  endtask

  task automatic model_eval();
    logic [NE-1:0] avail;
    avail = '0;
    for (int i = 0; i < 8; i++) if (rdy[i] && !m_iss[i]) avail[i] = 1'b1;
    for (int s = 0; s < NS-1; s++)
      if (m_cv[s] && rdy[m_ci[s]] && !m_iss[m_ci[s]]) avail[m_ci[s]] = 1'b1;
    e_vld = '0; e_grant = '0;
    for (int k = 0; k < 4; k++) begin
      bit got; int bi;
      got = 1'b0; bi = 0;
      e_idx[k] = '0;
      for (int i = 0; i < NE; i++)
        if (avail[i] && (!got || key(i) < key(bi))) begin got = 1'b1; bi = i; end
      if (got) begin
        e_vld[k] = 1'b1; e_idx[k] = IW'(bi); avail[bi] = 1'b0; e_grant[bi] = 1'b1;
      end
    end
  endtask

  task automatic model_advance();
    for (int s = 0; s < NS-1; s++) begin
      bit got; int bi;
      got = 1'b0; bi = 0;
      for (int j = 0; j < 8; j++) begin
        int i;
        i = (s+1)*8 + j;
        if (rdy[i] && !m_iss[i] && !e_grant[i] && (!got || key(i) < key(bi))) begin
          got = 1'b1; bi = i;
        end
      end
      m_cv[s] = got;
      m_ci[s] = got ? IW'(bi) : '0;
    end
    m_iss = (m_iss | e_grant) & rdy;
  endtask

  // Drive at the falling edge, compare against the model shortly after.
  task automatic drive(input logic [NE-1:0] r, input string tag);
    rdy = r;
    #2;
    model_eval();
    for (int k = 0; k < 4; k++) begin
      chk(slot_vld[k] === e_vld[k], tag, $sformatf("slot%0d valid", k), 32'(slot_vld[k]), 32'(e_vld[k]));
      if (e_vld[k])
        chk(slot_idx[k*IW +: IW] === e_idx[k], tag, $sformatf("slot%0d index", k),
            32'(slot_idx[k*IW +: IW]), 32'(e_idx[k]));
      else
        chk(slot_idx[k*IW +: IW] === '0, "R6", $sformatf("idle slot%0d index", k),
            32'(slot_idx[k*IW +: IW]), 32'h0);
    end
    chk(grant === e_grant, "R8", "grant vector", grant, e_grant);
  endtask

  task automatic tick();
    @(posedge clk);
    model_advance();
    @(negedge clk);
  endtask

  task automatic flush();
    drive('0, "R9"); tick();
    drive('0, "R9"); tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rdy = '0;
    model_clear();
    repeat (3) @(negedge clk);
    chk(slot_vld === 4'h0, "R1", "slots in reset", 32'(slot_vld), 32'h0);
    chk(grant === '0, "R1", "grant in reset", grant, 32'h0);
    rst_n = 1'b1;
    drive(32'h0000_FF00, "R1");
    chk(grant === '0, "R1", "first cycle grant", grant, 32'h0);
    tick();
    drive(32'h0000_FF00, "R3");
    chk($countones(grant) == 1, "R3", "one late grant", 32'($countones(grant)), 32'd1);
    tick();
    flush();
  endtask

  task automatic t_first_seg();
    for (int i = 0; i < NE; i++) ages[i] = AW'(40 - i);
    drive(32'h0000_00FF, "R2");
    chk(slot_vld === 4'hF, "R2", "same-cycle slots", 32'(slot_vld), 32'hF);
    chk(slot_idx[0 +: IW] === 5'd7, "R5", "oldest first", 32'(slot_idx[0 +: IW]), 32'd7);
    tick();
    drive(32'h0000_00FF, "R2"); tick();
    flush();
  endtask

  task automatic t_ties();
    for (int i = 0; i < NE; i++) ages[i] = AW'(5);
    drive(32'h0000_003C, "R5");
    chk(slot_idx[0 +: IW] === 5'd2, "R5", "tie to lower index", 32'(slot_idx[0 +: IW]), 32'd2);
    tick();
    flush();
  endtask

  task automatic t_latency();
    for (int i = 0; i < NE; i++) ages[i] = AW'(i);
    drive(32'h0010_0000, "R3");
    chk(grant === '0, "R3", "late entry first cycle", grant, 32'h0);
    tick();
    drive(32'h0010_0000, "R3");
    chk(grant === 32'h0010_0000, "R3", "late entry next cycle", grant, 32'h0010_0000);
    tick();
    drive(32'h0010_0000, "R7");
    chk(grant === '0, "R7", "no regrant of held entry", grant, 32'h0);
    tick();
    flush();
  endtask

  task automatic t_presel();
    for (int i = 0; i < 8; i++) ages[i] = AW'(30 + i);
    for (int i = 8; i < 16; i++) ages[i] = AW'(i - 8);
    for (int c = 0; c < 5; c++) begin
      drive(32'h0000_FFFF, "R4");
      chk($countones(grant[15:8]) <= 1, "R4", "segment 1 quota",
          32'($countones(grant[15:8])), 32'd1);
      tick();
    end
    flush();
  endtask

  task automatic t_regrant();
    for (int i = 0; i < NE; i++) ages[i] = AW'(i);
    drive(32'h0000_0008, "R7");
    chk(grant === 32'h8, "R7", "first grant", grant, 32'h8);
    tick();
    drive(32'h0000_0008, "R7");
    chk(grant === '0, "R7", "held entry blocked", grant, 32'h0);
    tick();
    drive('0, "R7"); tick();
    drive(32'h0000_0008, "R7");
    chk(grant === 32'h8, "R7", "grant after ready re-rise", grant, 32'h8);
    tick();
    flush();
  endtask

  task automatic t_sparse();
    for (int i = 0; i < NE; i++) ages[i] = AW'(63 - i);
    drive(32'h0000_0021, "R6");
    chk(slot_vld === 4'b0011, "R6", "partial fill", 32'(slot_vld), 32'h3);
    tick();
    flush();
  endtask

  task automatic t_drop();
    for (int i = 0; i < NE; i++) ages[i] = AW'(i);
    drive(32'h0002_0000, "R9"); tick();
    drive('0, "R9");
    chk(grant === '0, "R9", "dropped candidate", grant, 32'h0);
    tick();
    flush();
  endtask

  task automatic t_mixed();
    for (int c = 0; c < 400; c++) begin
      if (c % 16 == 0)
        for (int i = 0; i < NE; i++) ages[i] = AW'($urandom % 64);
      drive(NE'($urandom & $urandom), "R5");
      tick();
    end
    flush();
  endtask

  initial begin
    for (int i = 0; i < NE; i++) ages[i] = '0;
    @(negedge clk);
    t_reset();
    t_first_seg();
    t_ties();
    t_latency();
    t_presel();
    t_regrant();
    t_sparse();
    t_drop();
    t_mixed();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule